// File: doc/BRIEF.md
# Configuration Access Address Encoder

This block sits on the host side of a parallel expansion bus and turns one configuration-space request from software into the words that a bus configuration cycle needs. A request names a bus number, a device slot, a function, a byte offset into the 256-byte header, an access size and a read or write direction. A separate flag marks an access to the host's own configuration header. The block builds the address word and a command word that holds the byte enables. It also lines up write data on the correct byte lanes. On a read it shifts and masks the returned dword into the requested width.

The bus signalling is not part of the block. A target-side agent sees `cyc_valid` with the address and command words. It answers with a one-cycle `cyc_done` and an error flag, and returns read data in the same cycle. A failed address phase ends the request with a not-found status. A read then returns all ones, and a write gets no data strobe. A size/offset pair that has no byte-enable pattern is refused before any cycle starts. Requests enter one at a time through a valid/ready handshake. Each request produces exactly one registered response pulse.

Top module: `cfgx_engine`

## Requirements
- R1: With `req_local`=0 and `req_bus`=0, `cyc_addr` is (1 << slot) OR (function << 8) OR (offset with bits 1:0 cleared). This is the type 0 format: bits 1:0 come out clear except where a slot bit lands there.
- R2: With `req_local`=0 and a nonzero bus, `cyc_addr` = bus<<16 | slot<<11 | function<<8 | (offset & ~3) | 1. This is the type 1 format.
- R3: Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. The byte enables are active-low. A 1-byte access at offset low bits 0/1/2/3 gives 0xE/0xD/0xB/0x7. A 2-byte access at offset 0 gives 0xC and at offset 2 gives 0x3. A 4-byte access at offset 0 gives 0x0.
- R4: Size code 3, or any size/offset pair outside R3, is illegal. The response arrives in the cycle after acceptance with status 2 and data 0xFFFFFFFF, and `cyc_valid` never rises.
- R5: For an external access, `cyc_cmd` carries the byte enables in bits 7:4 and the command code in bits 3:0: 0xA for a read, 0xB for a write. All other bits are zero.
- R6: For a local access, `cyc_cmd` carries the byte enables in bits 23:20, bit 16 set for a write, and the offset with bits 1:0 cleared in bits 7:0. All other bits are zero. `cyc_addr` is the aligned offset.
- R7: `cyc_wdata` equals the write data shifted left by 8 × (offset mod 4). It is presented with a one-cycle `cyc_wr` pulse after an error-free address phase.
- R8: A successful read returns status 0. Its data is the target dword shifted right by 8 × (offset mod 4) and then masked to 8, 16 or 32 bits by size. A successful write returns status 0 with data 0.
- R9: When `cyc_done` arrives with `cyc_err` set, the block returns status 1 with data 0xFFFFFFFF, and `cyc_wr` does not pulse.
- R10: `req_ready` is high only when idle. It drops in the cycle after acceptance and rises again after the single one-cycle `rsp_valid` pulse.
- R11: While `cyc_valid` is high and `cyc_done` is low, `cyc_valid`, `cyc_addr` and `cyc_cmd` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted on this edge |
| req_local | input | 1 | Target the host's own header |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Bus number |
| req_slot | input | 5 | Device slot |
| req_func | input | 3 | Function number |
| req_off | input | 8 | Byte offset in the header |
| req_size | input | 2 | Size code (0/1/2 = 1/2/4 bytes) |
| req_wdata | input | 32 | Write value, right-aligned |
| cyc_valid | output | 1 | Address phase active |
| cyc_addr | output | 32 | Address word |
| cyc_cmd | output | 32 | Command and byte-enable word |
| cyc_wr | output | 1 | Write data strobe |
| cyc_wdata | output | 32 | Lane-aligned write data |
| cyc_done | input | 1 | Target finished address phase |
| cyc_err | input | 1 | Target reported an error with done |
| cyc_rdata | input | 32 | Target read dword, valid with done |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 not found, 2 illegal |
| rsp_rdata | output | 32 | Extracted read data |

## Verification
The assertions assume that `cyc_done` is a single-cycle pulse. They also assume it is raised only while `cyc_valid` is high, and that `cyc_err` and `cyc_rdata` have meaning only in that cycle. The bench's target stub drives all three at the falling edge only when it sees `cyc_valid`. It waits a programmable number of cycles before the pulse and clears the pulse again at the next falling edge. Requests are presented only while `req_ready` is high, and `req_valid` drops right after acceptance, so no request is ever offered to a busy engine.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int DATA_W = 32;
    localparam int BUS_W  = 8;
    localparam int SLOT_W = 5;
    localparam int FUNC_W = 3;
    localparam int OFF_W  = 8;
    localparam int BE_W   = DATA_W / 8;
    localparam int LO_W   = $clog2(BE_W);

    localparam int FUNC_LSB    = 8;
    localparam int T1_SLOT_LSB = 11;
    localparam int T1_BUS_LSB  = 16;
    localparam int EXT_BE_LSB  = 4;
    localparam int LOC_BE_LSB  = 20;
    localparam int LOC_WR_BIT  = 16;

    localparam logic [3:0] CODE_RD = 4'hA;
    localparam logic [3:0] CODE_WR = 4'hB;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_NOTFOUND = 2'd1,
        ST_ILLEGAL  = 2'd2
    } status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ADDR,
        S_DATA,
        S_RESP
    } state_e;

    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] wdata;
    } cyc_word_t;

    // Active-low lane enables for a size and the low offset bits; all ones = no legal pattern
    function automatic logic [BE_W-1:0] lane_enables(size_e sz, logic [LO_W-1:0] lo);
        logic [BE_W-1:0] on;
        on = '0;
        case (sz)
            SZ_BYTE: on = BE_W'(1) << lo;
            SZ_HALF: on = (lo[0] == 1'b0) ? (BE_W'(2'b11) << lo) : '0;
            SZ_WORD: on = (lo == '0) ? '1 : '0;
            default: on = '0;
        endcase
        return ~on;
    endfunction

    function automatic logic [DATA_W-1:0] size_mask(size_e sz);
        case (sz)
            SZ_BYTE: return DATA_W'(8'hFF);
            SZ_HALF: return DATA_W'(16'hFFFF);
            default: return '1;
        endcase
    endfunction

endpackage

// File: rtl/cfgx_addr_fmt.sv
module cfgx_addr_fmt
    import cfgx_pkg::*;
(
    input  logic              is_local,
    input  logic [BUS_W-1:0]  bus,
    input  logic [SLOT_W-1:0] slot,
    input  logic [FUNC_W-1:0] func,
    input  logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] addr
);
    logic [DATA_W-1:0] aligned;
    logic [DATA_W-1:0] type0;
    logic [DATA_W-1:0] type1;

    always_comb begin
        aligned = DATA_W'(off);
        aligned[LO_W-1:0] = '0;

        type0 = (DATA_W'(1) << slot)
              | (DATA_W'(func) << FUNC_LSB)
              | aligned;

        type1 = (DATA_W'(bus)  << T1_BUS_LSB)
              | (DATA_W'(slot) << T1_SLOT_LSB)
              | (DATA_W'(func) << FUNC_LSB)
              | aligned
              | DATA_W'(1);

        if (is_local)
            addr = aligned;
        else if (bus == '0)
            addr = type0;
        else
            addr = type1;
    end
endmodule

// File: rtl/cfgx_lane.sv
module cfgx_lane
    import cfgx_pkg::*;
(
    input  logic              is_local,
    input  logic              write,
    input  size_e             size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic              illegal,
    output logic [DATA_W-1:0] cmd,
    output logic [DATA_W-1:0] wdata_sh
);
    logic [BE_W-1:0]   be_n;
    logic [LO_W-1:0]   lo;
    logic [DATA_W-1:0] aligned;

    always_comb begin
        lo       = off[LO_W-1:0];
        be_n     = lane_enables(size, lo);
        illegal  = (be_n == '1);
        wdata_sh = wdata << (8 * lo);

        aligned = DATA_W'(off);
        aligned[LO_W-1:0] = '0;

        if (is_local)
            cmd = (DATA_W'(be_n) << LOC_BE_LSB)
                | (DATA_W'(write) << LOC_WR_BIT)
                | aligned;
        else
            cmd = (DATA_W'(be_n) << EXT_BE_LSB)
                | DATA_W'(write ? CODE_WR : CODE_RD);
    end
endmodule

// File: rtl/cfgx_rd_extract.sv
module cfgx_rd_extract
    import cfgx_pkg::*;
(
    input  logic [DATA_W-1:0] raw,
    input  logic [LO_W-1:0]   lo,
    input  size_e             size,
    output logic [DATA_W-1:0] value
);
    always_comb begin
        value = (raw >> (8 * lo)) & size_mask(size);
    end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
    import cfgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [LO_W-1:0]   req_lo,
    input  size_e             req_size,
    input  logic              illegal,
    input  cyc_word_t         next_word,
    output logic              cyc_valid,
    output logic [DATA_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_cmd,
    output logic              cyc_wr,
    output logic [DATA_W-1:0] cyc_wdata,
    input  logic              cyc_done,
    input  logic              cyc_err,
    output logic [LO_W-1:0]   held_lo,
    output size_e             held_size,
    input  logic [DATA_W-1:0] rd_value,
    output logic              rsp_valid,
    output logic [1:0]        rsp_status,
    output logic [DATA_W-1:0] rsp_rdata
);
    state_e    state;
    cyc_word_t word_q;
    logic      wr_q;
    status_e   status_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            word_q    <= '0;
            wr_q      <= 1'b0;
            held_lo   <= '0;
            held_size <= SZ_BYTE;
            status_q  <= ST_OK;
            rdata_q   <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        word_q    <= next_word;
                        wr_q      <= req_write;
                        held_lo   <= req_lo;
                        held_size <= req_size;
                        if (illegal) begin
                            status_q <= ST_ILLEGAL;
                            rdata_q  <= '1;
                            state    <= S_RESP;
                        end else begin
                            state <= S_ADDR;
                        end
                    end
                end
                S_ADDR: begin
                    if (cyc_done) begin
                        if (cyc_err) begin
                            status_q <= ST_NOTFOUND;
                            rdata_q  <= '1;
                            state    <= S_RESP;
                        end else if (wr_q) begin
                            status_q <= ST_OK;
                            rdata_q  <= '0;
                            state    <= S_DATA;
                        end else begin
                            status_q <= ST_OK;
                            rdata_q  <= rd_value;
                            state    <= S_RESP;
                        end
                    end
                end
                S_DATA:  state <= S_RESP;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == S_IDLE);
    assign cyc_valid  = (state == S_ADDR);
    assign cyc_wr     = (state == S_DATA);
    assign rsp_valid  = (state == S_RESP);
    assign cyc_addr   = word_q.addr;
    assign cyc_cmd    = word_q.cmd;
    assign cyc_wdata  = word_q.wdata;
    assign rsp_status = status_q;
    assign rsp_rdata  = rdata_q;

    // R10: acceptance makes the engine busy on the next cycle
    a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10: a response lasts exactly one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R4: an illegal size/offset answers at once and never opens a cycle
    a_r4_illegal_no_cycle: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && illegal) |=>
            (rsp_valid && !cyc_valid && rsp_status == ST_ILLEGAL && rsp_rdata == '1));

    // R9: a failed address phase gives not-found and no data strobe
    a_r9_err_no_data: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && cyc_done && cyc_err) |=>
            (rsp_valid && !cyc_wr && rsp_status == ST_NOTFOUND && rsp_rdata == '1));

    // R11: address and command hold until the target answers
    a_r11_hold_words: assert property (@(posedge clk) disable iff (rst)
        (cyc_valid && !cyc_done) |=>
            (cyc_valid && $stable(cyc_addr) && $stable(cyc_cmd)));

    // R7: a data strobe only follows an error-free address phase of a write
    a_r7_strobe_after_ok: assert property (@(posedge clk) disable iff (rst)
        cyc_wr |-> ($past(cyc_valid) && $past(cyc_done) && !$past(cyc_err)));
endmodule

// File: rtl/cfgx_engine.sv
module cfgx_engine
    import cfgx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_local,
    input  logic        req_write,
    input  logic [7:0]  req_bus,
    input  logic [4:0]  req_slot,
    input  logic [2:0]  req_func,
    input  logic [7:0]  req_off,
    input  logic [1:0]  req_size,
    input  logic [31:0] req_wdata,
    output logic        cyc_valid,
    output logic [31:0] cyc_addr,
    output logic [31:0] cyc_cmd,
    output logic        cyc_wr,
    output logic [31:0] cyc_wdata,
    input  logic        cyc_done,
    input  logic        cyc_err,
    input  logic [31:0] cyc_rdata,
    output logic        rsp_valid,
    output logic [1:0]  rsp_status,
    output logic [31:0] rsp_rdata
);
    size_e             size_in;
    logic              illegal;
    cyc_word_t         next_word;
    logic [LO_W-1:0]   held_lo;
    size_e             held_size;
    logic [DATA_W-1:0] rd_value;

    assign size_in = size_e'(req_size);

    cfgx_addr_fmt u_addr (
        .is_local (req_local),
        .bus      (req_bus),
        .slot     (req_slot),
        .func     (req_func),
        .off      (req_off),
        .addr     (next_word.addr)
    );

    cfgx_lane u_lane (
        .is_local (req_local),
        .write    (req_write),
        .size     (size_in),
        .off      (req_off),
        .wdata    (req_wdata),
        .illegal  (illegal),
        .cmd      (next_word.cmd),
        .wdata_sh (next_word.wdata)
    );

    cfgx_rd_extract u_rd (
        .raw   (cyc_rdata),
        .lo    (held_lo),
        .size  (held_size),
        .value (rd_value)
    );

    cfgx_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_lo     (req_off[LO_W-1:0]),
        .req_size   (size_in),
        .illegal    (illegal),
        .next_word  (next_word),
        .cyc_valid  (cyc_valid),
        .cyc_addr   (cyc_addr),
        .cyc_cmd    (cyc_cmd),
        .cyc_wr     (cyc_wr),
        .cyc_wdata  (cyc_wdata),
        .cyc_done   (cyc_done),
        .cyc_err    (cyc_err),
        .held_lo    (held_lo),
        .held_size  (held_size),
        .rd_value   (rd_value),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_rdata  (rsp_rdata)
    );
endmodule

// File: tb/cfgx_engine_test.sv
`timescale 1ns/1ps
module cfgx_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_local = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_slot = '0;
    logic [2:0]  req_func = '0;
    logic [7:0]  req_off = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        cyc_valid;
    logic [31:0] cyc_addr;
    logic [31:0] cyc_cmd;
    logic        cyc_wr;
    logic [31:0] cyc_wdata;
    logic        cyc_done = 1'b0;
    logic        cyc_err = 1'b0;
    logic [31:0] cyc_rdata = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int          stub_delay = 0;
    bit          stub_err = 0;
    logic [31:0] stub_rdata = '0;
    int          stub_cnt = 0;

    always #2.5 clk = ~clk;

    cfgx_engine uut (.*);

    // Target stub: answers after stub_delay falling edges of an open address phase
    always @(negedge clk) begin
        cyc_done = 1'b0;
        if (cyc_valid) begin
            if (stub_cnt == stub_delay) begin
                cyc_done  = 1'b1;
                cyc_err   = stub_err;
                cyc_rdata = stub_rdata;
                stub_cnt  = 0;
            end else begin
                stub_cnt++;
            end
        end else begin
            stub_cnt = 0;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_be(int size, int lo);
        if (size == 0) return 4'hF ^ (4'h1 << lo);
        if (size == 1 && lo == 0) return 4'hC;
        if (size == 1 && lo == 2) return 4'h3;
        if (size == 2 && lo == 0) return 4'h0;
        return 4'hF;
    endfunction

    task automatic run_req(bit loc, bit wr, int bus, int slot, int func, int off,
                           int size, logic [31:0] wd, int delay, bit err, logic [31:0] rd);
        logic [3:0]  be;
        logic [31:0] aligned, exp_addr, exp_cmd, exp_rd, mask;
        int          lo, exp_status;
        bit          saw_cyc, saw_wr, got_rsp;
        lo = off % 4;
        aligned = 32'(off) & ~32'h3;
        be = ref_be(size, lo);
        if (loc) begin
            exp_addr = aligned;
            exp_cmd  = (32'(be) << 20) | (32'(wr) << 16) | aligned;
        end else begin
            exp_cmd = (32'(be) << 4) | (wr ? 32'hB : 32'hA);
            if (bus == 0)
                exp_addr = (32'h1 << slot) | (32'(func) << 8) | aligned;
            else
                exp_addr = (32'(bus) << 16) | (32'(slot) << 11) | (32'(func) << 8) | aligned | 32'h1;
        end
        mask = (size == 0) ? 32'hFF : (size == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
        if (be == 4'hF) begin
            exp_status = 2; exp_rd = 32'hFFFF_FFFF;
        end else if (err) begin
            exp_status = 1; exp_rd = 32'hFFFF_FFFF;
        end else if (wr) begin
            exp_status = 0; exp_rd = 0;
        end else begin
            exp_status = 0; exp_rd = (rd >> (8 * lo)) & mask;
        end
        stub_delay = delay; stub_err = err; stub_rdata = rd;

        @(negedge clk);
        check("R10", 32'(req_ready), 1, "ready while idle");
        req_valid = 1; req_local = loc; req_write = wr; req_bus = 8'(bus);
        req_slot = 5'(slot); req_func = 3'(func); req_off = 8'(off);
        req_size = 2'(size); req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        saw_cyc = 0; saw_wr = 0; got_rsp = 0;
        for (int i = 0; i < 40 && !got_rsp; i++) begin
            if (cyc_valid && !saw_cyc) begin
                saw_cyc = 1;
                check(loc ? "R6" : (bus == 0 ? "R1" : "R2"), cyc_addr, exp_addr, "address word");
                check(loc ? "R6" : "R5", cyc_cmd, exp_cmd, "command word");
                check("R3", loc ? 32'(cyc_cmd[23:20]) : 32'(cyc_cmd[7:4]), 32'(be), "byte enables");
            end
            if (cyc_valid && saw_cyc && i > 0)
                check("R11", cyc_addr, exp_addr, "address held");
            if (cyc_wr) begin
                saw_wr = 1;
                check("R7", cyc_wdata, wd << (8 * lo), "lane write data");
            end
            if (rsp_valid) begin
                got_rsp = 1;
                check("R8", 32'(rsp_status), 32'(exp_status), "status");
                check("R8", rsp_rdata, exp_rd, "response data");
            end else begin
                check("R10", 32'(req_ready), 0, "ready low while busy");
                @(negedge clk);
            end
        end
        check("R10", 32'(got_rsp), 1, "response seen");
        check("R4", 32'(saw_cyc), (be == 4'hF) ? 0 : 1, "cycle issued");
        check("R9", 32'(saw_wr), (be != 4'hF && !err && wr) ? 1 : 0, "data strobe");
        @(negedge clk);
        check("R10", 32'(rsp_valid), 0, "single response pulse");
        check("R10", 32'(req_ready), 1, "ready after response");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R10", 32'(req_ready), 1, "reset ready");
        check("R11", 32'(cyc_valid), 0, "reset no cycle");
        check("R10", 32'(rsp_valid), 0, "reset no response");

        // R1 type 0, sizes and lanes (R3, R8)
        run_req(0, 0, 0, 12, 3, 8'h40, 2, 0, 0, 0, 32'hDEAD_BEEF);
        run_req(0, 0, 0, 3, 5, 8'h11, 0, 0, 2, 0, 32'h4433_2211);
        run_req(0, 0, 0, 20, 0, 8'h07, 0, 0, 1, 0, 32'hA1B2_C3D4);
        run_req(0, 0, 0, 1, 1, 8'h0E, 1, 0, 0, 0, 32'h8765_4321);
        run_req(0, 0, 0, 31, 7, 8'h04, 1, 0, 3, 0, 32'h1357_9BDF);
        // R2 type 1
        run_req(0, 0, 1, 9, 2, 8'hFC, 2, 0, 1, 0, 32'h0BAD_F00D);
        run_req(0, 1, 200, 31, 7, 8'h2A, 1, 32'h0000_ABCD, 2, 0, 0);
        // R7 writes at every byte lane
        for (int k = 0; k < 4; k++)
            run_req(0, 1, 0, 5, 0, 8'h20 + k, 0, 32'h0000_005A + k, k, 0, 0);
        // R6 local header access
        run_req(1, 1, 0, 0, 0, 8'h04, 2, 32'h0000_0156, 0, 0, 0);
        run_req(1, 1, 0, 0, 0, 8'h3D, 0, 32'h0000_00C7, 1, 0, 0);
        run_req(1, 0, 0, 0, 0, 8'h0A, 1, 0, 0, 0, 32'hCAFE_1234);
        // R4 illegal combinations
        run_req(0, 0, 0, 2, 0, 8'h01, 1, 0, 0, 0, 0);
        run_req(0, 1, 3, 2, 0, 8'h02, 2, 32'h1, 0, 0, 0);
        run_req(0, 0, 0, 2, 0, 8'h00, 3, 0, 0, 0, 0);
        run_req(1, 1, 0, 0, 0, 8'h03, 1, 32'h1, 0, 0, 0);
        // R9 error after address phase
        run_req(0, 0, 4, 6, 1, 8'h10, 2, 0, 2, 1, 32'h1234_5678);
        run_req(0, 1, 0, 6, 1, 8'h12, 1, 32'h0000_7777, 0, 1, 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog: actual hung expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule